// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block is a configurable logic cell of the kind found inside a complex programmable logic device. Thirty-six input signals are offered to a programmable AND array in both polarities, together with both polarities of the eighteen macrocell register states fed back locally. The array forms ninety product terms. A per-macrocell allocation mask picks which of those terms each of eighteen macrocells ORs together. One term may serve any number of macrocells, and a macrocell may take anything from none of them to all ninety.

Each macrocell presents either its OR sum directly or the value held in its register. The register is clocked by one of three global clocks chosen per macrocell. An asynchronous global set/reset loads every register with its own configured value. Each output carries an enable toward the pad side, and two configuration bits select what drives that enable.

The whole pattern arrives over a serial chain: one bit per configuration clock while a load enable is high. It goes into a shadow copy and only becomes active on a commit strobe. The logic therefore never runs on a half-loaded pattern.

Top module: `sop_logic_block`

## Requirements
- R1: After `cfg_rst_n` is low, the active pattern is all zero. Every output then reads 0 and every enable reads 0, whatever `din` and `goe` are.
- R2: Literal index l of term p is active when pattern bit p*108+l is 1. Indices 0..35 are `din` true, 36..71 are `din` inverted, 72..89 are the register states true and 90..107 are the register states inverted. A term is 1 exactly when all of its active literals are 1, so a term with no active literal is 1.
- R3: In combinational mode an output equals the OR of the terms whose bit is set at 9720+i*90+p. With no term allocated it is 0. Any number of terms, up to all 90, may be allocated, and one term may feed several macrocells.
- R4: Each macrocell has 13 control bits at base 11340+i*13: bit 0 registered mode, bits 2:1 clock select, bit 3 set/reset value, bits 5:4 enable mode, bits 12:6 enable term index. In registered mode the output is the register, which loads the OR sum on the rising edge of the selected clock only. Select 0, 1 and 2 pick `gclk[0]`, `gclk[1]` and `gclk[2]`; select 3 also picks `gclk[2]`.
- R5: The feedback literals carry each macrocell's register state, so a term can depend on registers and build counters inside the block.
- R6: While `gsr` is high, every register holds its configured set/reset value. This takes effect at once, with no clock edge needed.
- R7: Enable mode 0 forces the enable to 0 and mode 1 forces it to 1. Mode 2 follows `goe`. Mode 3 follows the term named by the index field, and an index of 90 or more gives 0.
- R8: While `cfg_en` is high, each `cfg_clk` edge shifts `cfg_sdi` into bit 0 of the shadow and moves every shadow bit up one place. After 11574 shifts, the bit sent first is at bit 11573.
- R9: The active pattern is replaced by the shadow only on a `cfg_clk` edge with `cfg_commit` high. Until then, a load in progress leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| cfg_rst_n | input | 1 | Active-low reset of shadow and active pattern |
| cfg_en | input | 1 | Shift enable for the serial chain |
| cfg_sdi | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copies the shadow into the active pattern |
| gclk | input | 3 | Global clocks for macrocell registers |
| gsr | input | 1 | Asynchronous global set/reset |
| goe | input | 1 | Global output-enable line |
| din | input | 36 | Logic inputs |
| dout | output | 18 | Macrocell outputs |
| dout_oe | output | 18 | Per-output enables |

## Verification
The hardest case to reach is a register state that depends on its own earlier value through the feedback literals. Such a state can only be reached through a full serial load, a set/reset and then a run of clock pulses. The stimulus loads a two-bit counter whose next state is formed purely from inverted and true feedback literals, presets it with unequal set/reset values, and steps it through its wrap-around. Other registers in the same pattern sit on the other clocks and must not move. Each load is also paused halfway, so that the bench can show the earlier pattern still governing the outputs.

// File: rtl/sop_pkg.sv
package sop_pkg;
    // Output-enable source selection, two bits per macrocell
    typedef enum logic [1:0] {
        OE_OFF    = 2'd0,
        OE_ON     = 2'd1,
        OE_GLOBAL = 2'd2,
        OE_TERM   = 2'd3
    } oe_mode_e;

    localparam int CSEL_W = 2;

    // Field offsets inside one macrocell control word
    localparam int F_REG  = 0;
    localparam int F_CSEL = 1;
    localparam int F_SRV  = 3;
    localparam int F_OEM  = 4;
    localparam int F_OPT  = 6;
endpackage

// File: rtl/sop_cfg_chain.sv
module sop_cfg_chain #(
    parameter int W = 64
) (
    input  logic         cfg_clk,
    input  logic         cfg_rst_n,
    input  logic         cfg_en,
    input  logic         cfg_sdi,
    input  logic         cfg_commit,
    output logic [W-1:0] active
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] live;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.shadow = {st_q.shadow[W-2:0], cfg_sdi};
        end
        if (cfg_commit) begin
            st_d.live = st_q.shadow;
        end
    end

    always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
        if (!cfg_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.live;

    p_shift_in_r8: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        cfg_en |=> st_q.shadow[0] == $past(cfg_sdi));

    p_shift_move_r8: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        cfg_en |=> st_q.shadow[W-1:1] == $past(st_q.shadow[W-2:0]));

    p_commit_copy_r9: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        cfg_commit |=> st_q.live == $past(st_q.shadow));

    p_live_hold_r9: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        !cfg_commit |=> $stable(st_q.live));
endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
    parameter int N_LIT = 108,
    parameter int N_PT  = 90
) (
    input  logic [N_LIT-1:0]      lit,
    input  logic [N_PT*N_LIT-1:0] mask,
    output logic [N_PT-1:0]       pt
);
    // A literal left out of the mask is forced to 1, so an empty term is 1
    for (genvar p = 0; p < N_PT; p++) begin : g_term
        assign pt[p] = &(lit | ~mask[p*N_LIT +: N_LIT]);
    end
endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int N_PT     = 90,
    parameter int N_CLK    = 3,
    parameter int PT_IDX_W = 7
) (
    input  logic [N_CLK-1:0]    gclk,
    input  logic                gsr,
    input  logic                goe,
    input  logic [N_PT-1:0]     pt,
    input  logic [N_PT-1:0]     alloc,
    input  logic                reg_en,
    input  logic [CSEL_W-1:0]   clk_sel,
    input  logic                srval,
    input  logic [1:0]          oe_mode,
    input  logic [PT_IDX_W-1:0] oe_pt,
    output logic                out,
    output logic                oe,
    output logic                state
);
    logic              sum_d;
    logic [N_CLK-1:0]  bank_q;
    logic [CSEL_W-1:0] sel_eff;

    always_comb begin
        sum_d = |(pt & alloc);
    end

    // One register per global clock; the select picks which one is seen
    for (genvar k = 0; k < N_CLK; k++) begin : g_bank
        logic q;
        always_ff @(posedge gclk[k] or posedge gsr) begin
            if (gsr) begin
                q <= srval;
            end else begin
                q <= sum_d;
            end
        end
        assign bank_q[k] = q;
    end

    always_comb begin
        if (int'(clk_sel) >= N_CLK) begin
            sel_eff = CSEL_W'(N_CLK - 1);
        end else begin
            sel_eff = clk_sel;
        end
        state = bank_q[sel_eff];
        out   = reg_en ? state : sum_d;
    end

    always_comb begin
        unique case (oe_mode_e'(oe_mode))
            OE_OFF:    oe = 1'b0;
            OE_ON:     oe = 1'b1;
            OE_GLOBAL: oe = goe;
            OE_TERM:   oe = (int'(oe_pt) < N_PT) ? pt[oe_pt] : 1'b0;
            default:   oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/sop_logic_block.sv
module sop_logic_block
    import sop_pkg::*;
#(
    parameter int N_IN  = 36,
    parameter int N_MC  = 18,
    parameter int N_PT  = 90,
    parameter int N_CLK = 3
) (
    input  logic             cfg_clk,
    input  logic             cfg_rst_n,
    input  logic             cfg_en,
    input  logic             cfg_sdi,
    input  logic             cfg_commit,
    input  logic [N_CLK-1:0] gclk,
    input  logic             gsr,
    input  logic             goe,
    input  logic [N_IN-1:0]  din,
    output logic [N_MC-1:0]  dout,
    output logic [N_MC-1:0]  dout_oe
);
    localparam int LIT_W    = 2 * N_IN + 2 * N_MC;
    localparam int MASK_W   = N_PT * LIT_W;
    localparam int ALLOC_W  = N_MC * N_PT;
    localparam int PT_IDX_W = $clog2(N_PT);
    localparam int MC_W     = F_OPT + PT_IDX_W;
    localparam int CTRL_B   = MASK_W + ALLOC_W;
    localparam int CFG_W    = CTRL_B + N_MC * MC_W;

    logic [CFG_W-1:0] cfg;
    logic [LIT_W-1:0] lit;
    logic [N_PT-1:0]  pt;
    logic [N_MC-1:0]  mc_state;
    logic [N_MC-1:0]  mc_srv;

    sop_cfg_chain #(.W(CFG_W)) u_chain (
        .cfg_clk    (cfg_clk),
        .cfg_rst_n  (cfg_rst_n),
        .cfg_en     (cfg_en),
        .cfg_sdi    (cfg_sdi),
        .cfg_commit (cfg_commit),
        .active     (cfg)
    );

    // Literal order: inputs true, inputs inverted, feedback true, feedback inverted
    assign lit = {~mc_state, mc_state, ~din, din};

    sop_and_array #(.N_LIT(LIT_W), .N_PT(N_PT)) u_array (
        .lit  (lit),
        .mask (cfg[MASK_W-1:0]),
        .pt   (pt)
    );

    for (genvar i = 0; i < N_MC; i++) begin : g_mc
        localparam int B = CTRL_B + i * MC_W;
        assign mc_srv[i] = cfg[B + F_SRV];

        sop_macrocell #(.N_PT(N_PT), .N_CLK(N_CLK), .PT_IDX_W(PT_IDX_W)) u_mc (
            .gclk    (gclk),
            .gsr     (gsr),
            .goe     (goe),
            .pt      (pt),
            .alloc   (cfg[MASK_W + i*N_PT +: N_PT]),
            .reg_en  (cfg[B + F_REG]),
            .clk_sel (cfg[B + F_CSEL +: CSEL_W]),
            .srval   (cfg[B + F_SRV]),
            .oe_mode (cfg[B + F_OEM +: 2]),
            .oe_pt   (cfg[B + F_OPT +: PT_IDX_W]),
            .out     (dout[i]),
            .oe      (dout_oe[i]),
            .state   (mc_state[i])
        );

        // Set/reset loads the configured value without any macrocell clock
        p_gsr_load_r6: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
            ($rose(gsr) && $stable(mc_srv[i])) |-> mc_state[i] == mc_srv[i]);
    end
endmodule

// File: tb/tb_sop_logic_block.sv
module tb_sop_logic_block;
    localparam int N_IN   = 36;
    localparam int N_MC   = 18;
    localparam int N_PT   = 90;
    localparam int N_CLK  = 3;
    localparam int LIT_W  = 2 * N_IN + 2 * N_MC;
    localparam int MASK_W = N_PT * LIT_W;
    localparam int CTRL_B = MASK_W + N_MC * N_PT;
    localparam int MC_W   = 13;
    localparam int CFG_W  = CTRL_B + N_MC * MC_W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             cfg_rst_n, cfg_en, cfg_sdi, cfg_commit, gsr, goe;
    logic [N_CLK-1:0] gclk;
    logic [N_IN-1:0]  din;
    logic [N_MC-1:0]  dout, dout_oe;

    sop_logic_block dut (
        .cfg_clk(clk), .cfg_rst_n(cfg_rst_n), .cfg_en(cfg_en), .cfg_sdi(cfg_sdi),
        .cfg_commit(cfg_commit), .gclk(gclk), .gsr(gsr), .goe(goe), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    typedef struct {
        bit       reg_en;
        bit [1:0] csel;
        bit       srv;
        bit [1:0] oem;
        bit [6:0] opt;
    } mcc_t;

    typedef struct {
        bit [N_MC-1:0] o;
        bit [N_MC-1:0] e;
        string         tag;
    } item_t;

    // Model: active (m_) and pending (n_) patterns, and register states
    bit [LIT_W-1:0] m_mask [N_PT];
    bit [LIT_W-1:0] n_mask [N_PT];
    bit [N_PT-1:0]  m_alloc [N_MC];
    bit [N_PT-1:0]  n_alloc [N_MC];
    mcc_t           m_mc [N_MC];
    mcc_t           n_mc [N_MC];
    bit [N_MC-1:0]  st;
    bit [CFG_W-1:0] vec;

    item_t q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    function automatic bit [N_PT-1:0] f_pt(bit [N_IN-1:0] x);
        bit [LIT_W-1:0] l = {~st, st, ~x, x};
        bit [N_PT-1:0] r;
        for (int p = 0; p < N_PT; p++) begin
            r[p] = 1'b1;
            for (int k = 0; k < LIT_W; k++) if (m_mask[p][k] && !l[k]) r[p] = 1'b0;
        end
        return r;
    endfunction

    function automatic bit [N_MC-1:0] f_sum(bit [N_IN-1:0] x);
        bit [N_PT-1:0] t = f_pt(x);
        bit [N_MC-1:0] s;
        for (int i = 0; i < N_MC; i++) s[i] = |(t & m_alloc[i]);
        return s;
    endfunction

    task automatic check(string tag);
        item_t it;
        bit [N_PT-1:0] t = f_pt(din);
        bit [N_MC-1:0] s = f_sum(din);
        for (int i = 0; i < N_MC; i++) begin
            it.o[i] = m_mc[i].reg_en ? st[i] : s[i];
            case (m_mc[i].oem)
                2'd0: it.e[i] = 1'b0;
                2'd1: it.e[i] = 1'b1;
                2'd2: it.e[i] = goe;
                default: it.e[i] = (m_mc[i].opt < N_PT) ? t[m_mc[i].opt] : 1'b0;
            endcase
        end
        it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    // Monitor: compares one queued expectation at each falling edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                n_chk++;
                if (dout !== it.o || dout_oe !== it.e) begin
                    n_err++;
                    $display("FAIL %s: dout=%h exp=%h oe=%h exp_oe=%h",
                             it.tag, dout, it.o, dout_oe, it.e);
                end
            end
        end
    end

    task automatic clear_next();
        for (int p = 0; p < N_PT; p++) n_mask[p] = '0;
        for (int i = 0; i < N_MC; i++) begin
            n_alloc[i] = '0;
            n_mc[i] = '{reg_en: 0, csel: 0, srv: 0, oem: 0, opt: 0};
        end
    endtask

    // R8: send the highest pattern bit first; R9: pause halfway and check
    task automatic load(string tag);
        for (int p = 0; p < N_PT; p++)
            for (int k = 0; k < LIT_W; k++) vec[p*LIT_W + k] = n_mask[p][k];
        for (int i = 0; i < N_MC; i++) begin
            int b = CTRL_B + i * MC_W;
            for (int p = 0; p < N_PT; p++) vec[MASK_W + i*N_PT + p] = n_alloc[i][p];
            vec[b]       = n_mc[i].reg_en;
            vec[b+1 +: 2] = n_mc[i].csel;
            vec[b+3]     = n_mc[i].srv;
            vec[b+4 +: 2] = n_mc[i].oem;
            vec[b+6 +: 7] = n_mc[i].opt;
        end
        for (int j = CFG_W - 1; j >= 0; j--) begin
            cfg_en = 1'b1;
            cfg_sdi = vec[j];
            @(posedge clk); #1;
            if (j == CFG_W / 2) begin
                cfg_en = 1'b0;
                din = 36'h5_A5A5_A5A5;
                check({"R9 half-loaded pattern has no effect ", tag});
            end
        end
        cfg_en = 1'b0;
        cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_commit = 1'b0;
        m_mask = n_mask;
        m_alloc = n_alloc;
        m_mc = n_mc;
    endtask

    task automatic pulse(int k);
        bit [N_MC-1:0] s = f_sum(din);
        for (int i = 0; i < N_MC; i++) begin
            int e = (m_mc[i].csel >= N_CLK) ? N_CLK - 1 : m_mc[i].csel;
            if (e == k) st[i] = s[i];
        end
        gclk[k] = 1'b1; #1; gclk[k] = 1'b0; #1;
    endtask

    task automatic set_reset(bit v);
        gsr = v;
        if (v) for (int i = 0; i < N_MC; i++) st[i] = m_mc[i].srv;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        cfg_rst_n = 1'b0; cfg_en = 1'b0; cfg_sdi = 1'b0; cfg_commit = 1'b0;
        gsr = 1'b1; goe = 1'b1; gclk = '0; din = '0; st = '0;
        clear_next();
        m_mask = n_mask; m_alloc = n_alloc; m_mc = n_mc;
        repeat (3) @(posedge clk);
        #1;
        cfg_rst_n = 1'b1;
        gsr = 1'b0;

        // R1: zero pattern, enables off even with goe high
        din = '1;
        check("R1 reset outputs and enables zero");
        din = 36'h9_1234_5678;
        goe = 1'b0;
        check("R1 reset state with other inputs");

        // Pattern A: combinational terms, sharing, full allocation, enables
        clear_next();
        n_mask[0][0] = 1; n_mask[0][36+1] = 1;   // in0 & ~in1
        n_mask[1][2] = 1; n_mask[1][3] = 1;      // in2 & in3
        n_mask[2][36+4] = 1;                     // ~in4
        for (int p = 4; p < N_PT; p++) begin     // in35 & ~in35 = 0
            n_mask[p][35] = 1; n_mask[p][71] = 1;
        end
        n_alloc[0][0] = 1; n_mc[0].oem = 2'd1;
        n_alloc[1][1] = 1; n_alloc[1][2] = 1; n_mc[1].oem = 2'd2;
        n_mc[2].oem = 2'd0;
        n_alloc[3][0] = 1; n_alloc[3][3] = 1; n_mc[3].oem = 2'd3; n_mc[3].opt = 7'd1;
        n_alloc[4] = '1; n_mc[4].oem = 2'd3; n_mc[4].opt = 7'd95;
        load("pattern A");

        din = 36'h0_0000_0001;
        goe = 1'b1;
        check("R2 R3 in0 and not in1, shared and constant term");
        din = 36'h0_0000_0003;
        check("R2 inverted literal blocks term");
        din = 36'h0_0000_001C;
        check("R3 R7 OR of two terms, term-driven enable");
        din = 36'h0_0000_0010;
        goe = 1'b0;
        check("R3 R7 global enable low, all 90 terms allocated");
        for (int r = 0; r < 16; r++) begin
            din = 36'({$urandom(), $urandom()});
            goe = 1'($urandom());
            check("R2 R3 R7 random inputs");
        end

        // Pattern B: registers, counter on feedback, clock selects
        clear_next();
        n_mask[0][90+0] = 1;                               // ~q0
        n_mask[1][72+1] = 1; n_mask[1][90+0] = 1;          // q1 & ~q0
        n_mask[2][90+1] = 1; n_mask[2][72+0] = 1;          // ~q1 & q0
        n_mask[3][0] = 1;                                  // in0
        n_mask[4][1] = 1;                                  // in1
        n_mask[5][2] = 1;                                  // in2
        n_alloc[0][0] = 1; n_mc[0] = '{reg_en: 1, csel: 0, srv: 1, oem: 1, opt: 0};
        n_alloc[1][1] = 1; n_alloc[1][2] = 1;
        n_mc[1] = '{reg_en: 1, csel: 0, srv: 0, oem: 0, opt: 0};
        n_alloc[2][3] = 1; n_mc[2] = '{reg_en: 1, csel: 1, srv: 1, oem: 3, opt: 3};
        n_alloc[3][4] = 1; n_mc[3] = '{reg_en: 1, csel: 2, srv: 0, oem: 0, opt: 0};
        n_alloc[4][5] = 1; n_mc[4] = '{reg_en: 1, csel: 3, srv: 1, oem: 2, opt: 0};
        n_alloc[5][0] = 1; n_mc[5].oem = 2'd1;
        load("pattern B");

        din = '0;
        set_reset(1'b1);
        check("R6 set/reset applies configured values without clock");
        din = '1;
        check("R6 registers held while set/reset high");
        set_reset(1'b0);
        din = '0;
        check("R6 values kept after release");

        for (int c = 0; c < 5; c++) begin
            pulse(0);
            check("R4 R5 feedback counter step");
        end

        din = 36'h0_0000_0006;
        pulse(1);
        check("R4 clock 1 loads only its macrocell");
        din = 36'h0_0000_0001;
        pulse(1);
        check("R4 clock 1 captures in0");
        din = 36'h0_0000_0000;
        check("R4 register holds without clock edge");
        din = 36'h0_0000_0006;
        pulse(2);
        check("R4 clock 2 serves select 2 and select 3");
        din = 36'h0_0000_0000;
        goe = 1'b1;
        check("R4 R7 held values after input change");
        set_reset(1'b1);
        check("R6 set/reset mid-run");
        set_reset(1'b0);

        // Pattern C: highest term, last literal, last macrocell
        clear_next();
        n_mask[N_PT-1][LIT_W-1] = 1;                       // ~q17
        n_alloc[N_MC-1][N_PT-1] = 1;
        n_mc[N_MC-1] = '{reg_en: 0, csel: 2, srv: 1, oem: 1, opt: 0};
        load("pattern C");
        check("R8 top-position fields decode, feedback inverted literal");
        pulse(2);
        check("R5 R8 comb output after its register moves");
        set_reset(1'b1);
        check("R6 set/reset under pattern C");
        set_reset(1'b0);

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule